// File: doc/BRIEF.md
# Requester Port Retry Adapter

This block sits between one requester and a shared, blocking cache. Each cycle the requester may offer a request. The adapter answers it in the same cycle: it either forwards the request and reports acceptance, or it refuses. A refused requester stays idle until the adapter sends it a one-cycle retry pulse, and then offers the request again. The adapter refuses a request in two cases: a response is still parked in the adapter, or the cache itself refused the forwarded request.

Responses from the cache go straight through to the requester in the cycle they arrive. If the requester does not take a response, the adapter parks it in a single holding register. The requester later raises its response-retry input, and the adapter presents the parked response again in that cycle. That offer may also be refused, in which case the response stays parked. The requester is never invited back with a retry pulse while a reply of its own is still parked.

The request and response paths are valid/ready. On the request side `rq_ready` is a same-cycle accept or refuse, and a refusal obliges the requester to wait for `rq_retry`. On the response side `rsp_ready` low is back-pressure, and the requester must later release the parked response with `rsp_retry`. The cache must not send a response while one is parked. If it does, the adapter reports the condition on `proto_err`.

Top module: `req_retry_adapter`

## Requirements
- R1: When no response is parked and no retry is pending, a valid request appears on `fw_valid`/`fw_data` in the same cycle, and `rq_ready` equals `fw_ready` in that cycle.
- R2: While a response is parked, a request is refused (`rq_ready` low) and is not forwarded (`fw_valid` low).
- R3: A request refused by the cache (`fw_ready` low) is refused to the requester, and a retry is scheduled for it.
- R4: A cache response (`cr_valid`) is presented on `rsp_valid`/`rsp_data` in the same cycle. If `rsp_ready` is low it is parked, and it is not lost.
- R5: When a response is parked, `rsp_retry` presents the parked data on `rsp_valid`/`rsp_data` in that cycle. If `rsp_ready` is low the data stays parked unchanged. `rsp_retry` with nothing parked produces no response.
- R6: `rq_retry` is a one-cycle pulse and is never high while a response is parked. After a refusal it comes in the cycle after the holding register is, or becomes, empty. The pending flag clears with the pulse, so one refusal yields exactly one pulse.
- R7: A cache response that arrives while a response is parked raises `proto_err` for one cycle, starting in the next cycle. The new response is not presented, and the parked data is kept.
- R8: A request offered in the same cycle as `rq_retry` is judged against the cleared flag, so it is forwarded and accepted if the cache accepts it.
- R9: After reset `rq_retry`, `proto_err`, `rsp_valid` and `fw_valid` are low, and nothing is parked.
- R10: Under random back-pressure on both sides, every response reaches the requester exactly once and in order, and the number of refusals equals the number of retry pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rq_valid | input | 1 | Requester offers a request |
| rq_data | input | REQ_W | Request payload |
| rq_ready | output | 1 | Request accepted this cycle (low = refused) |
| rq_retry | output | 1 | One-cycle invitation to re-offer a refused request |
| fw_valid | output | 1 | Request forwarded to the cache |
| fw_data | output | REQ_W | Forwarded payload |
| fw_ready | input | 1 | Cache accepts the forwarded request |
| cr_valid | input | 1 | Cache delivers a response |
| cr_data | input | RSP_W | Cache response payload |
| rsp_valid | output | 1 | Response offered to the requester |
| rsp_data | output | RSP_W | Response payload to the requester |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_retry | input | 1 | Requester asks for the parked response again |
| proto_err | output | 1 | Cache sent a response while one was parked |

## Verification
The in-RTL assertions check several rules on every cycle. A parked response stays put, with stable data, until it is delivered. A stalled response is captured. A refusal always leaves either a pending flag or a retry pulse behind. The retry pulse never coincides with a parked response. A response sent over a parked one raises the error. The directed scenarios cover the rest: the exact cycle of the retry pulse, acceptance of a request offered alongside the pulse, a resend that fails and then succeeds, and dropping of the illegal response. The random-stall stream checks end-to-end delivery with no loss or duplicate, and a one-to-one match between refusals and retries.

// File: rtl/rra_pkg.sv
package rra_pkg;
  localparam int unsigned RRA_REQ_W = 32;
  localparam int unsigned RRA_RSP_W = 32;

  // Outcome of a request offer, used for readability in the gate.
  typedef enum logic [1:0] {
    OFFER_NONE    = 2'd0,
    OFFER_TAKEN   = 2'd1,
    OFFER_REFUSED = 2'd2
  } offer_e;
endpackage

// File: rtl/rra_rsp_hold.sv
module rra_rsp_hold #(
  parameter int unsigned RSP_W = rra_pkg::RRA_RSP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cr_valid,
  input  logic [RSP_W-1:0] cr_data,
  input  logic             rsp_ready,
  input  logic             rsp_retry,
  output logic             rsp_valid,
  output logic [RSP_W-1:0] rsp_data,
  output logic             hold_q,
  output logic             hold_nxt,
  output logic             proto_err
);
  logic [RSP_W-1:0] hold_data;
  logic             resend;
  logic             clash;
  logic             park_new;

  // A parked entry is offered again only on an explicit retry.
  assign resend   = hold_q && rsp_retry;
  // A fresh response over a parked one is illegal and is dropped.
  assign clash    = cr_valid && hold_q;
  assign park_new = cr_valid && !hold_q && !rsp_ready;

  always_comb begin
    rsp_valid = resend || (cr_valid && !hold_q);
    rsp_data  = resend ? hold_data : cr_data;
    if (hold_q) hold_nxt = !(resend && rsp_ready);
    else        hold_nxt = park_new;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= 1'b0;
      hold_data <= '0;
      proto_err <= 1'b0;
    end else begin
      hold_q    <= hold_nxt;
      proto_err <= clash;
      if (park_new) hold_data <= cr_data;
    end
  end

  // R5: a parked entry survives, unchanged, until delivered
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !(rsp_retry && rsp_ready)) |=> (hold_q && $stable(hold_data)));

  // R4: a stalled fresh response is captured
  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_valid && !hold_q && !rsp_ready) |=> (hold_q && hold_data == $past(cr_data)));

  // R7: illegal overlap is reported next cycle
  p_clash_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_valid && hold_q) |=> proto_err);
endmodule

// File: rtl/rra_req_gate.sv
module rra_req_gate #(
  parameter int unsigned REQ_W = rra_pkg::RRA_REQ_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rq_valid,
  input  logic [REQ_W-1:0] rq_data,
  input  logic             fw_ready,
  input  logic             hold_q,
  input  logic             hold_nxt,
  output logic             rq_ready,
  output logic             rq_retry,
  output logic             fw_valid,
  output logic [REQ_W-1:0] fw_data
);
  import rra_pkg::*;

  logic   need_q;
  logic   retry_q;
  logic   blocked;
  logic   need_pre;
  offer_e offer;

  assign blocked  = hold_q || need_q;
  assign fw_valid = rq_valid && !blocked;
  assign fw_data  = rq_data;
  assign rq_ready = fw_valid && fw_ready;
  assign rq_retry = retry_q;

  always_comb begin
    if (!rq_valid)     offer = OFFER_NONE;
    else if (rq_ready) offer = OFFER_TAKEN;
    else               offer = OFFER_REFUSED;
  end

  // The flag is sticky until the port is fully free. The pulse is issued
  // from the next-cycle holding state, so a resend that frees the port
  // schedules the invitation at once.
  assign need_pre = need_q || (offer == OFFER_REFUSED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      need_q  <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      need_q  <= need_pre && hold_nxt;
      retry_q <= need_pre && !hold_nxt;
    end
  end

  // R3: every refusal leaves a pending flag or an immediate pulse
  p_refusal_tracked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && !rq_ready) |=> (need_q || rq_retry));

  // R6: no invitation while a reply is still parked
  p_retry_when_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rq_retry |-> !hold_q);

  // R6: the flag is gone in the pulse cycle
  p_flag_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rq_retry |-> !need_q);
endmodule

// File: rtl/req_retry_adapter.sv
module req_retry_adapter #(
  parameter int unsigned REQ_W = rra_pkg::RRA_REQ_W,
  parameter int unsigned RSP_W = rra_pkg::RRA_RSP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rq_valid,
  input  logic [REQ_W-1:0] rq_data,
  output logic             rq_ready,
  output logic             rq_retry,
  output logic             fw_valid,
  output logic [REQ_W-1:0] fw_data,
  input  logic             fw_ready,
  input  logic             cr_valid,
  input  logic [RSP_W-1:0] cr_data,
  output logic             rsp_valid,
  output logic [RSP_W-1:0] rsp_data,
  input  logic             rsp_ready,
  input  logic             rsp_retry,
  output logic             proto_err
);
  logic hold_q;
  logic hold_nxt;

  rra_rsp_hold #(.RSP_W(RSP_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .cr_valid  (cr_valid),
    .cr_data   (cr_data),
    .rsp_ready (rsp_ready),
    .rsp_retry (rsp_retry),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .hold_q    (hold_q),
    .hold_nxt  (hold_nxt),
    .proto_err (proto_err)
  );

  rra_req_gate #(.REQ_W(REQ_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .rq_valid (rq_valid),
    .rq_data  (rq_data),
    .fw_ready (fw_ready),
    .hold_q   (hold_q),
    .hold_nxt (hold_nxt),
    .rq_ready (rq_ready),
    .rq_retry (rq_retry),
    .fw_valid (fw_valid),
    .fw_data  (fw_data)
  );

  // R2: nothing reaches the cache while a reply is parked
  p_no_fwd_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> !fw_valid);
endmodule

// File: tb/test_req_retry_adapter.sv
`timescale 1ns/1ps
module test_req_retry_adapter;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         rq_valid, rq_ready, rq_retry;
  logic [W-1:0] rq_data;
  logic         fw_valid, fw_ready;
  logic [W-1:0] fw_data;
  logic         cr_valid;
  logic [W-1:0] cr_data;
  logic         rsp_valid, rsp_ready, rsp_retry, proto_err;
  logic [W-1:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  req_retry_adapter #(.REQ_W(W), .RSP_W(W)) i_req_retry_adapter (
    .clk(clk), .rst_n(rst_n),
    .rq_valid(rq_valid), .rq_data(rq_data), .rq_ready(rq_ready), .rq_retry(rq_retry),
    .fw_valid(fw_valid), .fw_data(fw_data), .fw_ready(fw_ready),
    .cr_valid(cr_valid), .cr_data(cr_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready),
    .rsp_retry(rsp_retry), .proto_err(proto_err)
  );

  task automatic chk(input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic idle();
    rq_valid = 0; rq_data = '0; fw_ready = 0; cr_valid = 0; cr_data = '0;
    rsp_ready = 0; rsp_retry = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    chk("R9 rq_retry", rq_retry, 0);
    chk("R9 proto_err", proto_err, 0);
    chk("R9 rsp_valid", rsp_valid, 0);
    chk("R9 fw_valid", fw_valid, 0);
  endtask

  task automatic t_pass();
    @(negedge clk); idle();
    rq_valid = 1; rq_data = 32'hA5A5_0001; fw_ready = 1;
    cr_valid = 1; cr_data = 32'h5555_0001; rsp_ready = 1;
    #2;
    chk("R1 fw_valid", fw_valid, 1);
    chk("R1 fw_data", fw_data, 32'hA5A5_0001);
    chk("R1 rq_ready", rq_ready, 1);
    chk("R4 rsp_valid", rsp_valid, 1);
    chk("R4 rsp_data", rsp_data, 32'h5555_0001);
    @(negedge clk); idle();
    rsp_retry = 1; rsp_ready = 1;
    #2;
    chk("R5 retry with empty hold", rsp_valid, 0);
    chk("R6 no pulse after accept", rq_retry, 0);
  endtask

  task automatic t_cache_refuse();
    @(negedge clk); idle();
    rq_valid = 1; rq_data = 32'h0000_00C1; fw_ready = 0;
    #2;
    chk("R3 refused", rq_ready, 0);
    chk("R3 offered to cache", fw_valid, 1);
    @(negedge clk); idle();
    rq_valid = 1; rq_data = 32'h0000_00C1; fw_ready = 1;
    #2;
    chk("R6 pulse after refusal", rq_retry, 1);
    chk("R8 accepted in pulse cycle", rq_ready, 1);
    @(negedge clk); idle();
    #2;
    chk("R6 pulse one cycle", rq_retry, 0);
  endtask

  task automatic t_hold();
    @(negedge clk); idle();
    cr_valid = 1; cr_data = 32'h0000_0011; rsp_ready = 0;
    #2;
    chk("R4 offered", rsp_valid, 1);
    @(negedge clk); idle();
    rq_valid = 1; fw_ready = 1; rq_data = 32'h77;
    #2;
    chk("R2 refused while parked", rq_ready, 0);
    chk("R2 not forwarded", fw_valid, 0);
    chk("R4 not re-offered unasked", rsp_valid, 0);
    @(negedge clk); idle();
    #2;
    chk("R6 no pulse while parked", rq_retry, 0);
    @(negedge clk); idle();
    rsp_retry = 1; rsp_ready = 0;
    #2;
    chk("R5 resend valid", rsp_valid, 1);
    chk("R5 resend data", rsp_data, 32'h0000_0011);
    @(negedge clk); idle();
    rsp_retry = 1; rsp_ready = 1;
    #2;
    chk("R6 no pulse after failed resend", rq_retry, 0);
    chk("R5 kept after failed resend", rsp_data, 32'h0000_0011);
    chk("R5 resend valid again", rsp_valid, 1);
    @(negedge clk); idle();
    #2;
    chk("R6 pulse right after resend", rq_retry, 1);
    @(negedge clk); idle();
    #2;
    chk("R6 single pulse", rq_retry, 0);
  endtask

  task automatic t_error();
    @(negedge clk); idle();
    cr_valid = 1; cr_data = 32'h22; rsp_ready = 0;
    @(negedge clk); idle();
    cr_valid = 1; cr_data = 32'h33; rsp_ready = 1;
    #2;
    chk("R7 illegal response not offered", rsp_valid, 0);
    @(negedge clk); idle();
    rsp_retry = 1; rsp_ready = 1;
    #2;
    chk("R7 error raised", proto_err, 1);
    chk("R7 parked data kept", rsp_data, 32'h22);
    @(negedge clk); idle();
    #2;
    chk("R7 error one cycle", proto_err, 0);
  endtask

  task automatic t_stream();
    int n = 40;
    int sent = 0, got = 0, refusals = 0, pulses = 0, spurious = 0, dup = 0;
    bit waiting = 0, owe = 0, pend = 0, pend_nxt;
    logic [W-1:0] pend_id = '0;
    logic [15:0] lfsr = 16'hACE1;
    for (int cyc = 0; cyc < 3000 && got < n; cyc++) begin
      @(negedge clk); idle();
      if (rq_retry) begin
        if (waiting) pulses++; else spurious++;
        waiting = 0;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rq_valid  = (sent < n) && !waiting;
      rq_data   = W'(sent);
      fw_ready  = (lfsr[5] | lfsr[9]) && !pend;
      cr_valid  = pend;
      cr_data   = pend_id;
      rsp_ready = lfsr[0] | lfsr[3];
      rsp_retry = owe && rsp_ready;
      #2;
      pend_nxt = 0;
      if (rq_valid) begin
        if (rq_ready) begin pend_nxt = 1; pend_id = W'(sent); sent++; end
        else begin waiting = 1; refusals++; end
      end
      if (rsp_valid) begin
        if (rsp_ready) begin
          if (rsp_data !== W'(got)) dup++;
          got++; owe = 0;
        end else owe = 1;
      end
      pend = pend_nxt;
    end
    chk("R10 all responses delivered", W'(got), W'(n));
    chk("R10 order, no loss or duplicate", W'(dup), 0);
    chk("R10 refusals match pulses", W'(refusals), W'(pulses));
    chk("R6 no uninvited pulse", W'(spurious), 0);
    chk("R10 stream saw refusals", W'(refusals > 0), 1);
  endtask

  initial begin
    t_reset();
    t_pass();
    t_cache_refuse();
    t_hold();
    t_error();
    t_stream();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule